// File: doc/BRIEF.md
# Row Multiply-Accumulate with Bias Preload

This block is the arithmetic core that forms one element of a matrix-vector product plus a bias. It takes a stream of signed operand pairs, multiplies each pair, and sums the products into a signed two's-complement register. A row starts from a preloaded bias value instead of from zero. Because the bias enters the register first, overflow detection sees it before any product.

A surrounding controller owns the operand memories, the handshake and the sequencing. It pulses a clear between rows, pulses the bias load, and raises the accumulate strobe for exactly one cycle per product that must be counted. The product and a delayed copy of the strobe pass through a register stage. The sum feeds back to the adder only from its own register, so there is no combinational loop.

A sticky flag records that some addition in the current row left the signed range. The wrapped value stays in the register and accumulation continues from it.

Top module: `biased_row_mac`

## Requirements
- R1: After synchronous reset, `row_sum` is 0 and `row_ovf` is 0.
- R2: A cycle with `mac_en` high captures the signed product `mul_a * mul_b`, sign-extended to the sum width. It is added to `row_sum` at the second rising edge after the inputs are sampled, so the new sum is visible two clocks after `mac_en` was presented.
- R3: Each cycle with `mac_en` high adds exactly one product. The same operand values presented on consecutive strobed cycles are added once per cycle, neither merged nor skipped.
- R4: When no clear, no bias load and no captured product fall due at an edge, `row_sum` and `row_ovf` keep their values, whatever values `mul_a`, `mul_b` and `bias_in` carry.
- R5: `row_clr` sets `row_sum` to 0 and `row_ovf` to 0 at the next edge. It wins over a bias load and over a product due at that edge, and it discards that product. A `mac_en` in the same cycle as `row_clr` is also discarded.
- R6: `bias_ld` (without `row_clr`) replaces `row_sum` with `bias_in` at the next edge and leaves `row_ovf` unchanged. A product due at that same edge is dropped. A `mac_en` presented together with `bias_ld` is kept and added after the bias.
- R7: An addition sets `row_ovf` when the old sum and the product have the same sign bit and the result's sign bit differs.
- R8: Once set, `row_ovf` stays 1 until `row_clr` or reset, even when later additions bring the sum back into range.
- R9: After an overflow, `row_sum` holds the wrapped 16-bit two's-complement result, and later additions continue from that wrapped value.
- R10: The bias is the first addend of a row. Overflow status therefore follows the order bias, then products in strobe order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| row_clr | input | 1 | Clear sum, flag and the in-flight product |
| bias_ld | input | 1 | Load `bias_in` as the starting sum |
| bias_in | input | 16 | Signed bias value |
| mac_en | input | 1 | Strobe: capture one product this cycle |
| mul_a | input | 8 | Signed operand A |
| mul_b | input | 8 | Signed operand B |
| row_sum | output | 16 | Signed accumulated sum |
| row_ovf | output | 1 | Sticky signed-overflow flag for the row |

## Verification
The hardest situations to reach from the ports are collisions at one edge: a product in flight meeting a clear or a bias load, and a wrapped sum that later comes back into range while the flag must stay set. Directed sequences time a bias load and a clear to land exactly on the edge where a captured product falls due. Other sequences drive full-scale products (-128 times -128) onto a bias near the positive limit so the sum wraps and then returns. A long random phase with dense strobes, repeated equal operands and sporadic loads and clears then compares every cycle against a behavioural model.

// File: rtl/brm_pkg.sv
package brm_pkg;

    localparam int DEF_OP_W  = 8;
    localparam int DEF_ACC_W = 16;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_ADD   = 2'd3
    } acc_act_e;

    // Priority: clear, then bias load, then a due product.
    function automatic acc_act_e pick_action(input logic clr, input logic ld, input logic due);
        if (clr)      return ACT_CLEAR;
        else if (ld)  return ACT_LOAD;
        else if (due) return ACT_ADD;
        else          return ACT_HOLD;
    endfunction

endpackage

// File: rtl/brm_product.sv
module brm_product
    import brm_pkg::*;
#(
    parameter int OP_W  = DEF_OP_W,
    parameter int ACC_W = DEF_ACC_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    en,
    input  logic signed [OP_W-1:0]  a,
    input  logic signed [OP_W-1:0]  b,
    output logic signed [ACC_W-1:0] prod_q,
    output logic                    due_q
);
    localparam int FULL_W = 2 * OP_W;

    logic signed [FULL_W-1:0] full_prod;
    logic signed [ACC_W-1:0]  fit_prod;

    assign full_prod = a * b;

    generate
        if (FULL_W >= ACC_W) begin : g_trim
            assign fit_prod = full_prod[ACC_W-1:0];
        end else begin : g_extend
            assign fit_prod = {{(ACC_W-FULL_W){full_prod[FULL_W-1]}}, full_prod};
        end
    endgenerate

    // Delayed strobe: one capture per strobed cycle, no change detection.
    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q <= '0;
            due_q  <= 1'b0;
        end else begin
            due_q <= en & ~clr;
            if (en & ~clr) prod_q <= fit_prod;
        end
    end

    AST_STROBE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (en && !clr) |=> due_q) else $error("strobe lost");   // R3
    AST_CLR_KILLS_STROBE: assert property (@(posedge clk) disable iff (rst)
        clr |=> !due_q) else $error("strobe survived clear"); // R5

endmodule

// File: rtl/brm_accum.sv
module brm_accum
    import brm_pkg::*;
#(
    parameter int ACC_W = DEF_ACC_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    ld,
    input  logic signed [ACC_W-1:0] bias,
    input  logic                    due,
    input  logic signed [ACC_W-1:0] prod,
    output logic signed [ACC_W-1:0] sum_q,
    output logic                    ovf_q
);
    localparam int MSB = ACC_W - 1;

    acc_act_e         act;
    logic [ACC_W-1:0] add_res;
    logic             add_ovf;

    assign act     = pick_action(clr, ld, due);
    assign add_res = sum_q + prod;
    assign add_ovf = (sum_q[MSB] == prod[MSB]) && (add_res[MSB] != sum_q[MSB]);

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            unique case (act)
                ACT_CLEAR: begin
                    sum_q <= '0;
                    ovf_q <= 1'b0;
                end
                ACT_LOAD:  sum_q <= bias;
                ACT_ADD: begin
                    sum_q <= add_res;
                    ovf_q <= ovf_q | add_ovf;
                end
                default: ;
            endcase
        end
    end

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
        clr |=> (sum_q == '0 && !ovf_q)) else $error("clear");               // R5
    AST_LOAD_BIAS: assert property (@(posedge clk) disable iff (rst)
        (ld && !clr) |=> (sum_q == $past(bias) && ovf_q == $past(ovf_q))) else $error("load"); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clr && !ld && !due) |=> ($stable(sum_q) && $stable(ovf_q))) else $error("hold"); // R4
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !clr) |=> ovf_q) else $error("sticky");                    // R8
    AST_OVF_FROM_ADD: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_q) |-> ($past(due) && !$past(clr) && !$past(ld))) else $error("ovf src"); // R7

endmodule

// File: rtl/biased_row_mac.sv
module biased_row_mac
    import brm_pkg::*;
#(
    parameter int OP_W  = DEF_OP_W,
    parameter int ACC_W = DEF_ACC_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    row_clr,
    input  logic                    bias_ld,
    input  logic signed [ACC_W-1:0] bias_in,
    input  logic                    mac_en,
    input  logic signed [OP_W-1:0]  mul_a,
    input  logic signed [OP_W-1:0]  mul_b,
    output logic signed [ACC_W-1:0] row_sum,
    output logic                    row_ovf
);
    logic signed [ACC_W-1:0] prod_q;
    logic                    due_q;

    brm_product #(.OP_W(OP_W), .ACC_W(ACC_W)) u_prod (
        .clk    (clk),
        .rst    (rst),
        .clr    (row_clr),
        .en     (mac_en),
        .a      (mul_a),
        .b      (mul_b),
        .prod_q (prod_q),
        .due_q  (due_q)
    );

    brm_accum #(.ACC_W(ACC_W)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .clr   (row_clr),
        .ld    (bias_ld),
        .bias  (bias_in),
        .due   (due_q),
        .prod  (prod_q),
        .sum_q (row_sum),
        .ovf_q (row_ovf)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (row_sum == '0 && !row_ovf)) else $error("reset"); // R1

endmodule

// File: tb/sim_biased_row_mac.sv
module sim_biased_row_mac;
    localparam int OP_W  = 8;
    localparam int ACC_W = 16;
    localparam int LIM   = 200000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic row_clr = 1'b0, bias_ld = 1'b0, mac_en = 1'b0;
    logic signed [ACC_W-1:0] bias_in = '0;
    logic signed [OP_W-1:0]  mul_a = '0, mul_b = '0;
    logic signed [ACC_W-1:0] row_sum;
    logic                    row_ovf;

    int n_chk = 0, n_bad = 0, cyc = 0;
    string cur_req = "R1";

    // behavioural model state
    int  m_sum = 0, m_prod = 0;
    bit  m_ovf = 0, m_due = 0;

    always #10 clk = ~clk;

    biased_row_mac #(.OP_W(OP_W), .ACC_W(ACC_W)) u0 (
        .clk(clk), .rst(rst), .row_clr(row_clr), .bias_ld(bias_ld), .bias_in(bias_in),
        .mac_en(mac_en), .mul_a(mul_a), .mul_b(mul_b), .row_sum(row_sum), .row_ovf(row_ovf)
    );

    function automatic int wrap(input int v);
        int t;
        t = v & 32'hFFFF;
        if (t >= 32768) t = t - 65536;
        return t;
    endfunction

    always @(posedge clk) begin
        int s;
        if (rst) begin
            m_sum = 0; m_ovf = 0; m_due = 0; m_prod = 0;
        end else begin
            if (row_clr) begin
                m_sum = 0; m_ovf = 0;
            end else if (bias_ld) begin
                m_sum = int'(bias_in);
            end else if (m_due) begin
                s = m_sum + m_prod;
                if (s > 32767 || s < -32768) m_ovf = 1;
                m_sum = wrap(s);
            end
            m_due = mac_en && !row_clr;
            if (m_due) m_prod = int'(mul_a) * int'(mul_b);
        end
    end

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            check({cur_req, " sum"}, int'(row_sum), m_sum);
            check({cur_req, " ovf"}, int'(row_ovf), int'(m_ovf));
        end
    end

    task automatic drive(input bit c, input bit l, input int bv, input bit e, input int a, input int b);
        @(negedge clk);
        row_clr = c; bias_ld = l; bias_in = ACC_W'(bv);
        mac_en = e; mul_a = OP_W'(a); mul_b = OP_W'(b);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 12345, 0, 77, -99);
    endtask

    initial begin
        while (cyc < LIM) begin
            @(posedge clk);
            cyc++;
        end
        n_bad++;
        $display("FAIL watchdog: got %0d cycles expected fewer than %0d", cyc, LIM);
        $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 reset sum", int'(row_sum), 0);
        check("R1 reset ovf", int'(row_ovf), 0);

        // R2 latency and signed product; R10 bias first
        cur_req = "R2";
        drive(0, 1, 100, 1, -7, 9);
        drive(0, 0, 0, 0, 0, 0);
        @(negedge clk);
        check("R2 bias then product", int'(row_sum), 100 - 63);
        idle(2);

        // R3 repeated equal operands, each added
        cur_req = "R3";
        drive(1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) drive(0, 0, 0, 1, 5, 5);
        idle(2);
        check("R3 four equal products", int'(row_sum), 100);

        // R4 inputs toggle without strobes
        cur_req = "R4";
        for (int i = 0; i < 5; i++) drive(0, 0, i * 999, 0, i * 13, -i);
        check("R4 unchanged", int'(row_sum), 100);

        // R5 clear colliding with due product
        cur_req = "R5";
        drive(0, 0, 0, 1, 20, 20);
        drive(1, 1, 555, 1, 3, 3);
        idle(2);
        check("R5 clear wins", int'(row_sum), 0);

        // R6 load colliding with due product
        cur_req = "R6";
        drive(0, 0, 0, 1, 10, 10);
        drive(0, 1, -40, 0, 0, 0);
        idle(2);
        check("R6 product dropped", int'(row_sum), -40);

        // R7/R9/R8/R10: bias near top, full-scale products wrap, then come back
        cur_req = "R7";
        drive(1, 0, 0, 0, 0, 0);
        drive(0, 1, 32000, 1, 10, 100);
        idle(2);
        check("R9 wrapped sum", int'(row_sum), 33000 - 65536);
        check("R7 flag set", int'(row_ovf), 1);
        cur_req = "R8";
        drive(0, 0, 0, 1, -128, -128);
        drive(0, 0, 0, 1, 10, 10);
        idle(2);
        check("R9 continues from wrap", int'(row_sum), 33000 - 65536 + 16384 + 100);
        check("R8 still set", int'(row_ovf), 1);
        drive(0, 1, 7, 0, 0, 0);
        idle(1);
        check("R8 survives load", int'(row_ovf), 1);
        cur_req = "R10";
        drive(1, 0, 0, 0, 0, 0);
        drive(0, 1, -30000, 1, -128, 127);
        drive(0, 0, 0, 1, -128, 127);
        idle(2);
        check("R10 negative wrap", int'(row_ovf), 1);

        // random phase
        cur_req = "R3";
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            drive(r < 3, (r >= 3 && r < 8), $urandom_range(0, 65535) - 32768,
                  $urandom_range(0, 9) < 7, $urandom_range(0, 3) == 0 ? -128 : $urandom_range(0, 255) - 128,
                  $urandom_range(0, 3) == 0 ? 127 : $urandom_range(0, 255) - 128);
        end
        idle(3);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule